// File: doc/BRIEF.md
# Loadable Down Counter with Zero Flag

The block is a synchronous down counter with a default width of three bits. On each rising clock edge it does one of three things. It clears to zero, it takes a parallel data word, or it steps down by one. When it steps down from zero it wraps to the all-ones value. A combinational zero flag is high in every cycle in which the count is zero. A seven-segment pattern for the low three bits of the count is decoded alongside the count.

A mode input makes the block a divide-by-(data+1) counter. In that mode the zero flag also requests a reload, so the count runs from the data word down to zero and then reloads the data word. The external load still forces a reload at any time. Clear overrides everything. There is no reset pin: the counter reaches a defined state on the first edge at which clear is high.

Top module: `dcount_tmo`

## Requirements
- R1: When `clr` is high at a rising edge, `cnt` becomes zero after that edge, whatever `ld`, `mod_en` and `din` are.
- R2: When `clr` is low and `ld` is high at a rising edge, `cnt` equals the value `din` had at that edge.
- R3: When `clr` and `ld` are low and no modulo reload applies, `cnt` decreases by one at each edge, and wraps from 0 to 2^W-1.
- R4: `tmo` is high in exactly those cycles in which `cnt` is zero, in the same cycle and with no register delay.
- R5: `seg` is bit 6 = segment a down to bit 0 = segment g, decoded from `cnt[2:0]`. Values 0 to 7 give hex 7E, 30, 6D, 79, 33, 5B, 5F, 70.
- R6: With `mod_en` high and `clr` low, an edge at which `cnt` is zero loads `din`. With `din` held at d, the count therefore repeats d, d-1, ..., 0 with period d+1.
- R7: A load of zero raises `tmo` in the cycle after the load edge. In modulo mode, a data word of zero holds `cnt` at zero with `tmo` high on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clr | input | 1 | Synchronous clear, highest priority |
| ld | input | 1 | Synchronous parallel load |
| din | input | W | Data word for loads and modulo reloads |
| mod_en | input | 1 | Modulo mode: zero flag also triggers a reload |
| cnt | output | W | Current count |
| tmo | output | 1 | High while the count is zero |
| seg | output | 7 | Seven-segment pattern, bit 6 = a |

## Verification
Clear, load, decrement and modulo reload each act through the single count register. Their results are therefore due one edge after the stimulus. The zero flag and the segment pattern follow the count within the same cycle. The bench applies each stimulus just after a falling edge and compares count, flag and pattern at the following falling edge. That sample point lies one register stage after the stimulus and half a period away from the active edge. The bench computes the expected count from the priority rules: clear first, then load or modulo reload, then decrement.

// File: rtl/dcount_tmo.sv
module dcount_tmo #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         clr,
  input  logic         ld,
  input  logic [W-1:0] din,
  input  logic         mod_en,
  output logic [W-1:0] cnt,
  output logic         tmo,
  output logic [6:0]   seg
);

  logic reload;

  assign tmo    = (cnt == '0);
  assign reload = ld | (mod_en & tmo);

  always_ff @(posedge clk) begin
    if (clr)         cnt <= '0;
    else if (reload) cnt <= din;
    else             cnt <= cnt - W'(1);
  end

  always_comb begin
    case (cnt[2:0])
      3'd0:    seg = 7'h7E;
      3'd1:    seg = 7'h30;
      3'd2:    seg = 7'h6D;
      3'd3:    seg = 7'h79;
      3'd4:    seg = 7'h33;
      3'd5:    seg = 7'h5B;
      3'd6:    seg = 7'h5F;
      default: seg = 7'h70;
    endcase
  end

  logic armed = 1'b0;
  always_ff @(posedge clk) if (clr) armed <= 1'b1;

  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!armed)
    clr |=> (cnt == '0)); // R1
  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!armed)
    (!clr && ld) |=> (cnt == $past(din))); // R2
  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!armed)
    (!clr && !ld && !(mod_en && tmo)) |=> (cnt == $past(cnt) - W'(1))); // R3
  AST_MOD_RELOAD: assert property (@(posedge clk) disable iff (!armed)
    (!clr && mod_en && tmo) |=> (cnt == $past(din))); // R6
  AST_SEG_ZERO: assert property (@(posedge clk) disable iff (!armed)
    tmo |-> (seg == 7'h7E)); // R5
  AST_ZERO_HOLD: assert property (@(posedge clk) disable iff (!armed)
    (!clr && mod_en && tmo && din == '0) |=> tmo); // R7

endmodule

// File: tb/dcount_tmo_test.sv
`timescale 1ns/1ps
module dcount_tmo_test;
  localparam int W = 3;

  logic clk = 1'b0;
  logic clr = 1'b1, ld = 1'b0, mod_en = 1'b0;
  logic [W-1:0] din = '0;
  logic [W-1:0] cnt;
  logic tmo;
  logic [6:0] seg;

  int runs = 0, fails = 0;
  bit done = 1'b0;
  logic [W-1:0] m = '0;

  always #5 clk = ~clk;

  dcount_tmo #(.W(W)) uut (.clk(clk), .clr(clr), .ld(ld), .din(din),
    .mod_en(mod_en), .cnt(cnt), .tmo(tmo), .seg(seg));

  function automatic logic [6:0] seg_of(input int v);
    case (v % 8)
      0: return 7'h7E; 1: return 7'h30; 2: return 7'h6D; 3: return 7'h79;
      4: return 7'h33; 5: return 7'h5B; 6: return 7'h5F; default: return 7'h70;
    endcase
  endfunction

  task automatic check(input string tag);
    runs++;
    if (cnt !== m) begin
      fails++;
      $display("FAIL %s cnt actual=%0d expected=%0d", tag, cnt, m);
    end
    runs++;
    if (tmo !== (m == 0)) begin
      fails++;
      $display("FAIL R4 tmo actual=%0b expected=%0b", tmo, (m == 0));
    end
    runs++;
    if (seg !== seg_of(int'(m))) begin
      fails++;
      $display("FAIL R5 seg actual=%h expected=%h", seg, seg_of(int'(m)));
    end
  endtask

  task automatic step(input logic c, input logic l, input logic [W-1:0] d,
                      input logic md, input string tag);
    clr = c; ld = l; din = d; mod_en = md;
    if (c)                    m = '0;
    else if (l || (md && m == 0)) m = d;
    else                      m = m - 1'b1;
    @(negedge clk);
    check(tag);
  endtask

  initial begin
    @(negedge clk);
    m = '0;
    check("R1");
    for (int i = 0; i < 10; i++) step(0, 0, 3'd6, 0, "R3");
    step(0, 1, 3'd5, 0, "R2");
    for (int i = 0; i < 9; i++) step(0, 0, 3'd0, 0, "R3");
    step(1, 1, 3'd7, 1, "R1");
    step(0, 1, 3'd3, 0, "R2");
    step(1, 1, 3'd3, 0, "R1");
    step(0, 1, 3'd0, 0, "R7");
    step(0, 0, 3'd0, 0, "R3");
    step(0, 1, 3'd4, 0, "R2");
    for (int i = 0; i < 12; i++) step(0, 0, 3'd4, 1, "R6");
    for (int d = 0; d < 8; d++)
      for (int i = 0; i < 2 * (d + 1) + 1; i++)
        step(0, 0, 3'(d), 1, d == 0 ? "R7" : "R6");
    begin
      logic [7:0] lf = 8'hA5;
      for (int i = 0; i < 400; i++) begin
        logic c, l, md;
        string t;
        lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
        c  = (lf[3:0] == 4'hF);
        l  = (lf[5:4] == 2'b11);
        md = lf[6];
        if (c) t = "R1";
        else if (l) t = "R2";
        else if (md && m == 0) t = "R6";
        else t = "R3";
        step(c, l, lf[2:0] ^ lf[7:5], md, t);
      end
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      runs++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", runs, fails);
      $finish;
    end
  end
endmodule